// File: doc/BRIEF.md
# Masked Packed Lane Execution Wrapper

This block turns a set of 64-bit element units into one packed vector operation of 128, 256 or 512 bits. Each lane runs an exponent-extraction unit, which returns the unbiased binary exponent of a double-precision input as a double-precision value. Around the lanes, the block applies a per-lane write mask. Lanes that are masked off either keep the old destination or are cleared, depending on the masking mode. When the source comes from memory and broadcast is requested, the block feeds element 0 to every lane. It clears the destination above the selected length and merges the per-lane exception flags. It also decodes the conditions that make the operation illegal.

A decode or issue stage drives all inputs in the same cycle. One cycle later the registered destination, the flags and the undefined-opcode indication appear. There is no handshake: a new operation may be presented every cycle.

Top module: `packed_lane_exec`

## Requirements
- R1: `vlen_i` codes 0, 1 and 2 select 128, 256 and 512 bits, that is 2, 4 and 8 lanes of 64 bits. Lane j occupies `dst_o[64*j+63:64*j]`.
- R2: Every destination bit at or above the selected length is 0, whatever the mask, the mode or `old_dst_i`.
- R3: A lane inside the length is active when `mask_en_i` is 0 or when its bit of `mask_i` is 1.
- R4: With `zero_mode_i` = 0, an inactive lane inside the length outputs its slice of `old_dst_i`.
- R5: With `zero_mode_i` = 1, an inactive lane inside the length outputs 0.
- R6: With `bcast_i` = 1 and `src_mem_i` = 1, every active lane operates on `src_i[63:0]`. With `src_mem_i` = 0, `bcast_i` has no effect and lane j uses its own source slice.
- R7: `ud_o` is 1 whenever `rsvd_i` differs from 4'b1111.
- R8: `ud_o` is also 1 for `vlen_i` code 3, and for `sae_i` = 1 at any length other than 512 bits.
- R9: When `ud_o` is 1, `dst_o` equals the full `old_dst_i` of that operation and `flags_o` is 0.
- R10: `flags_o` bit 0 (invalid) and bit 1 (denormal) are the OR of the flags of active lanes only. A masked-off or out-of-length lane contributes nothing.
- R11: With `sae_i` = 1 at 512 bits, `flags_o` is 0 and lane results are still written.
- R12: Lane function:
  - Finite nonzero normal x yields floor(log2|x|), that is biased exponent minus 1023, as a double.
  - A subnormal input with its highest set fraction bit at position p yields p-1074 and raises denormal.
  - Either zero yields 64'hFFF0_0000_0000_0000.
  - Either infinity yields 64'h7FF0_0000_0000_0000.
  - A NaN yields its own bits with fraction bit 51 set, and raises invalid when bit 51 was 0.
- R13: Outputs are registered with one cycle of latency. While `rst_ni` is low, `dst_o`, `flags_o` and `ud_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 512 | Source vector, lane j at bits 64j+63:64j |
| old_dst_i | input | 512 | Current destination contents |
| mask_i | input | 8 | Per-lane write mask |
| mask_en_i | input | 1 | Write mask in use |
| zero_mode_i | input | 1 | 1: zero inactive lanes, 0: merge |
| vlen_i | input | 2 | Length code: 0=128, 1=256, 2=512, 3 illegal |
| bcast_i | input | 1 | Broadcast element 0 |
| src_mem_i | input | 1 | Source operand comes from memory |
| sae_i | input | 1 | Suppress all exceptions |
| rsvd_i | input | 4 | Reserved operand specifier, must be 4'b1111 |
| dst_o | output | 512 | New destination |
| flags_o | output | 2 | bit 0 invalid, bit 1 denormal |
| ud_o | output | 1 | Undefined-opcode indication |

## Verification
Masking and flag reduction meet in the same cycle when a signaling NaN sits in a masked-off lane and a subnormal sits in an active lane. The bench provokes this and requires `flags_o` to carry only the denormal bit while the masked lane shows merged or zeroed data. A second collision comes from an illegal encoding presented together with exception-raising operands and a mask. Here the undefined-opcode path must win: the whole old destination must pass through with no flags. Length clearing and merging also overlap when a 128-bit operation carries a non-zero old destination. That old destination must still leave the upper lanes at 0.

// File: rtl/plx_pkg.sv
package plx_pkg;
  localparam int FLAG_W  = 2;
  localparam int FLG_INV = 0;
  localparam int FLG_DEN = 1;

  // index of highest set bit, 0 when none
  function automatic int msb_idx(input logic [63:0] v);
    int idx;
    idx = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/lane_exp_unit.sv
module lane_exp_unit
  import plx_pkg::*;
#(
  parameter int W      = 64,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [W-1:0]      op_i,
  output logic [W-1:0]      res_o,
  output logic [FLAG_W-1:0] flg_o
);
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int SUB_BASE = 1 - BIAS - FRAC_W;
  localparam int IW       = EXP_W + 2;

  logic [EXP_W-1:0]         exp_f;
  logic [FRAC_W-1:0]        frac_f;
  logic signed [IW-1:0]     int_val;

  assign exp_f  = op_i[W-2 -: EXP_W];
  assign frac_f = op_i[FRAC_W-1:0];

  function automatic logic [W-1:0] int2fp(input logic signed [IW-1:0] v);
    logic [IW-1:0] mag;
    logic [W-1:0]  sh;
    int            q;
    if (v == '0) return '0;
    mag = v[IW-1] ? IW'(-v) : IW'(v);
    q   = msb_idx(64'(mag));
    sh  = W'(mag) << (FRAC_W - q);
    return {v[IW-1], EXP_W'(BIAS + q), sh[FRAC_W-1:0]};
  endfunction

  always_comb begin
    res_o   = '0;
    flg_o   = '0;
    int_val = '0;
    if (exp_f == '1) begin
      if (frac_f != '0) begin
        res_o = op_i;
        res_o[FRAC_W-1] = 1'b1;
        flg_o[FLG_INV]  = ~frac_f[FRAC_W-1];
      end else begin
        res_o = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
    end else if (exp_f == '0 && frac_f == '0) begin
      res_o = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      if (exp_f == '0) begin
        int_val        = IW'(msb_idx(64'(frac_f))) + IW'(SUB_BASE);
        flg_o[FLG_DEN] = 1'b1;
      end else begin
        int_val = IW'(exp_f) - IW'(BIAS);
      end
      res_o = int2fp(int_val);
    end
  end
endmodule

// File: rtl/lane_operand_sel.sv
module lane_operand_sel #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64
) (
  input  logic [LANES*LANE_W-1:0] src_i,
  input  logic                    bcast_i,
  input  logic                    src_mem_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic                    mask_en_i,
  input  logic [LANES-1:0]        in_len_i,
  output logic [LANES*LANE_W-1:0] op_o,
  output logic [LANES-1:0]        act_o
);
  logic use_elem0;
  assign use_elem0 = bcast_i & src_mem_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign op_o[j*LANE_W +: LANE_W] = use_elem0 ? src_i[LANE_W-1:0]
                                                : src_i[j*LANE_W +: LANE_W];
    assign act_o[j] = in_len_i[j] & (~mask_en_i | mask_i[j]);
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import plx_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 64
) (
  input  logic [LANES*LANE_W-1:0] res_i,
  input  logic [LANES*FLAG_W-1:0] flg_i,
  input  logic [LANES-1:0]        act_i,
  input  logic [LANES-1:0]        in_len_i,
  input  logic [LANES*LANE_W-1:0] old_i,
  input  logic                    zero_mode_i,
  output logic [LANES*LANE_W-1:0] dst_o,
  output logic [FLAG_W-1:0]       flg_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      if (!in_len_i[j])     dst_o[j*LANE_W +: LANE_W] = '0;
      else if (act_i[j])    dst_o[j*LANE_W +: LANE_W] = res_i[j*LANE_W +: LANE_W];
      else if (zero_mode_i) dst_o[j*LANE_W +: LANE_W] = '0;
      else                  dst_o[j*LANE_W +: LANE_W] = old_i[j*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    flg_o = '0;
    for (int j = 0; j < LANES; j++) begin
      if (act_i[j]) flg_o = flg_o | flg_i[j*FLAG_W +: FLAG_W];
    end
  end
endmodule

// File: rtl/packed_lane_exec.sv
module packed_lane_exec
  import plx_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int LANE_W    = 64,
  parameter int MIN_LANES = 2,
  parameter int RSV_W     = 4,
  localparam int VEC_W     = LANES * LANE_W,
  localparam int LEN_CODES = $clog2(LANES / MIN_LANES) + 1,
  localparam int VL_W      = $clog2(LEN_CODES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [VEC_W-1:0]  old_dst_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic              mask_en_i,
  input  logic              zero_mode_i,
  input  logic [VL_W-1:0]   vlen_i,
  input  logic              bcast_i,
  input  logic              src_mem_i,
  input  logic              sae_i,
  input  logic [RSV_W-1:0]  rsvd_i,
  output logic [VEC_W-1:0]  dst_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              ud_o
);
  localparam int TOP_CODE = LEN_CODES - 1;

  logic                    len_ok;
  logic [LANES-1:0]        in_len;
  logic [LANES-1:0]        act;
  logic [VEC_W-1:0]        ops;
  logic [VEC_W-1:0]        res;
  logic [LANES*FLAG_W-1:0] lane_flg;
  logic [VEC_W-1:0]        merged;
  logic [FLAG_W-1:0]       red_flg;
  logic                    ud_d;

  assign len_ok = (int'(vlen_i) < LEN_CODES);

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      in_len[j] = len_ok && (j < (MIN_LANES << vlen_i));
    end
  end

  assign ud_d = (rsvd_i != '1) | ~len_ok |
                (sae_i & (int'(vlen_i) != TOP_CODE));

  lane_operand_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_opsel (
    .src_i     (src_i),
    .bcast_i   (bcast_i),
    .src_mem_i (src_mem_i),
    .mask_i    (mask_i),
    .mask_en_i (mask_en_i),
    .in_len_i  (in_len),
    .op_o      (ops),
    .act_o     (act)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_unit
    lane_exp_unit #(.W(LANE_W)) u_exp (
      .op_i  (ops[j*LANE_W +: LANE_W]),
      .res_o (res[j*LANE_W +: LANE_W]),
      .flg_o (lane_flg[j*FLAG_W +: FLAG_W])
    );
  end

  lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .res_i       (res),
    .flg_i       (lane_flg),
    .act_i       (act),
    .in_len_i    (in_len),
    .old_i       (old_dst_i),
    .zero_mode_i (zero_mode_i),
    .dst_o       (merged),
    .flg_o       (red_flg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o   <= '0;
      flags_o <= '0;
      ud_o    <= 1'b0;
    end else begin
      ud_o    <= ud_d;
      dst_o   <= ud_d ? old_dst_i : merged;
      flags_o <= (ud_d | sae_i) ? '0 : red_flg;
    end
  end
endmodule

// File: rtl/packed_lane_exec_chk.sv
module packed_lane_exec_chk #(
  parameter int LANES     = 8,
  parameter int LANE_W    = 64,
  parameter int MIN_LANES = 2,
  parameter int RSV_W     = 4,
  parameter int VL_W      = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [LANES*LANE_W-1:0] old_dst_i,
  input logic                    mask0_i,
  input logic                    mask_en_i,
  input logic                    zero_mode_i,
  input logic [VL_W-1:0]         vlen_i,
  input logic                    sae_i,
  input logic [RSV_W-1:0]        rsvd_i,
  input logic [LANES*LANE_W-1:0] dst_o,
  input logic [1:0]              flags_o,
  input logic                    ud_o
);
  localparam int VEC_W = LANES * LANE_W;
  localparam int MIN_W = MIN_LANES * LANE_W;

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R9
  ud_keeps_dst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && ud_o) |-> dst_o == $past(old_dst_i));
  // R9
  ud_no_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_o |-> flags_o == '0);
  // R7
  rsvd_ud_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(rsvd_i) != '1) |-> ud_o);
  // R11
  sae_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(sae_i)) |-> flags_o == '0);
  // R2
  short_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ud_o && $past(vlen_i) == '0) |-> dst_o[VEC_W-1:MIN_W] == '0);
  // R5
  zero_lane0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ud_o && $past(mask_en_i && zero_mode_i && !mask0_i))
      |-> dst_o[LANE_W-1:0] == '0);
  // R4
  merge_lane0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !ud_o && $past(mask_en_i && !zero_mode_i && !mask0_i))
      |-> dst_o[LANE_W-1:0] == $past(old_dst_i[LANE_W-1:0]));
endmodule

bind packed_lane_exec packed_lane_exec_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .MIN_LANES(MIN_LANES),
  .RSV_W(RSV_W), .VL_W(VL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .old_dst_i   (old_dst_i),
  .mask0_i     (mask_i[0]),
  .mask_en_i   (mask_en_i),
  .zero_mode_i (zero_mode_i),
  .vlen_i      (vlen_i),
  .sae_i       (sae_i),
  .rsvd_i      (rsvd_i),
  .dst_o       (dst_o),
  .flags_o     (flags_o),
  .ud_o        (ud_o)
);

// File: tb/packed_lane_exec_test.sv
`timescale 1ns/1ps
module packed_lane_exec_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [511:0] src = '0, old_dst = '0;
  logic [7:0]   mask = '0;
  logic         mask_en = 0, zero_mode = 0, bcast = 0, src_mem = 0, sae = 0;
  logic [1:0]   vlen = 2'd2;
  logic [3:0]   rsvd = 4'hF;
  logic [511:0] dst;
  logic [1:0]   flags;
  logic         ud;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  packed_lane_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .old_dst_i(old_dst),
    .mask_i(mask), .mask_en_i(mask_en), .zero_mode_i(zero_mode),
    .vlen_i(vlen), .bcast_i(bcast), .src_mem_i(src_mem), .sae_i(sae),
    .rsvd_i(rsvd), .dst_o(dst), .flags_o(flags), .ud_o(ud)
  );

  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] EIGHT = 64'h4020_0000_0000_0000;
  localparam logic [63:0] QUART = 64'h3FD0_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] QNAN  = 64'hFFF8_0000_0000_0abc;
  localparam logic [63:0] DEN1  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] DENH  = 64'h8008_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] BIG   = 64'h7FEF_FFFF_FFFF_FFFF;

  // {den, inv, result}
  function automatic logic [65:0] ref_lane(input logic [63:0] x);
    logic [10:0] e;
    logic [51:0] f;
    int n, p;
    e = x[62:52];
    f = x[51:0];
    if (e == 11'h7FF) begin
      if (f != 0) return {1'b0, ~f[51], x | 64'h0008_0000_0000_0000};
      return {2'b00, 64'h7FF0_0000_0000_0000};
    end
    if (e == 0 && f == 0) return {2'b00, 64'hFFF0_0000_0000_0000};
    if (e == 0) begin
      p = 0;
      for (int i = 0; i < 52; i++) if (f[i]) p = i;
      n = p - 1074;
      return {2'b10, $realtobits(real'(n))};
    end
    n = int'(e) - 1023;
    return {2'b00, $realtobits(real'(n))};
  endfunction

  task automatic model(output logic [511:0] ed, output logic [1:0] ef,
                       output logic eu);
    logic [65:0] r;
    logic [63:0] x;
    int nl;
    eu = (rsvd != 4'hF) || (vlen == 2'd3) || (sae && vlen != 2'd2);
    ed = '0;
    ef = '0;
    if (eu) begin
      ed = old_dst;
      return;
    end
    nl = 2 << vlen;
    for (int j = 0; j < 8; j++) begin
      if (j >= nl) ed[j*64 +: 64] = '0;
      else if (!mask_en || mask[j]) begin
        x = (bcast && src_mem) ? src[63:0] : src[j*64 +: 64];
        r = ref_lane(x);
        ed[j*64 +: 64] = r[63:0];
        ef = ef | {r[65], r[64]};
      end else ed[j*64 +: 64] = zero_mode ? 64'd0 : old_dst[j*64 +: 64];
    end
    if (sae) ef = '0;
  endtask

  task automatic chk(input string tag, input logic [511:0] act,
                     input logic [511:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic run_case(input string tag);
    logic [511:0] ed;
    logic [1:0]   ef;
    logic         eu;
    model(ed, ef, eu);
    @(negedge clk);
    chk({tag, " dst"}, dst, ed);
    chk({tag, " flags"}, 512'(flags), 512'(ef));
    chk({tag, " ud"}, 512'(ud), 512'(eu));
  endtask

  task automatic defaults();
    mask_en = 0; zero_mode = 0; bcast = 0; src_mem = 0; sae = 0;
    vlen = 2'd2; rsvd = 4'hF; mask = '0;
  endtask

  task automatic t_reset();
    old_dst = {8{64'h1111_2222_3333_4444}};
    src = {8{ONE}};
    #5;
    chk("R13 reset dst", dst, '0);
    chk("R13 reset flags", 512'(flags), '0);
    chk("R13 reset ud", 512'(ud), '0);
  endtask

  task automatic t_lane_values();
    defaults();
    src = {BIG, NINF, DENH, DEN1, QNAN, SNAN, QUART, EIGHT};
    run_case("R12 lane values");
    src = {64'h0, 64'h8000_0000_0000_0000, 64'h7FF0_0000_0000_0000,
           64'h0000_0000_0000_0003, ONE, 64'hC010_0000_0000_0000,
           64'h0010_0000_0000_0000, 64'h3FEF_FFFF_FFFF_FFFF};
    run_case("R12 zeros infs edges");
  endtask

  task automatic t_lengths();
    defaults();
    src = {EIGHT, QUART, ONE, EIGHT, QUART, ONE, EIGHT, QUART};
    old_dst = {8{64'hAAAA_5555_AAAA_5555}};
    for (int v = 0; v < 3; v++) begin
      vlen = 2'(v);
      run_case("R1 R2 length");
    end
    vlen = 2'd0; mask_en = 1; mask = 8'hFF;
    run_case("R2 upper cleared with mask");
  endtask

  task automatic t_masking();
    defaults();
    src = {QUART, EIGHT, ONE, QUART, EIGHT, ONE, QUART, EIGHT};
    old_dst = {64'h8, 64'h7, 64'h6, 64'h5, 64'h4, 64'h3, 64'h2, 64'h1};
    mask_en = 1; mask = 8'b1010_0110;
    run_case("R3 R4 merge");
    zero_mode = 1;
    run_case("R3 R5 zero");
    mask_en = 0;
    run_case("R3 mask unused");
    mask_en = 1; mask = 8'h00; zero_mode = 0; vlen = 2'd1;
    run_case("R4 all masked merge");
  endtask

  task automatic t_bcast();
    defaults();
    src = {ONE, ONE, ONE, ONE, ONE, ONE, ONE, EIGHT};
    bcast = 1; src_mem = 1;
    run_case("R6 bcast memory");
    chk("R6 lane7 uses elem0", dst[511:448], 64'h4008_0000_0000_0000);
    src_mem = 0;
    run_case("R6 bcast register ignored");
    chk("R6 lane7 own elem", dst[511:448], 64'h0);
  endtask

  task automatic t_flags();
    defaults();
    src = {ONE, ONE, ONE, ONE, DEN1, ONE, ONE, SNAN};
    old_dst = {8{64'h0123_4567_89AB_CDEF}};
    mask_en = 1; mask = 8'b0000_1000;
    run_case("R10 masked snan");
    chk("R10 only denormal", 512'(flags), 512'(2'b10));
    mask = 8'b0000_0001;
    run_case("R10 active snan");
    chk("R10 only invalid", 512'(flags), 512'(2'b01));
    mask_en = 0; vlen = 2'd0;
    run_case("R10 out-of-length denormal");
  endtask

  task automatic t_ud();
    defaults();
    src = {8{SNAN}};
    old_dst = {8{64'hDEAD_BEEF_0000_0001}};
    mask_en = 1; mask = 8'h0F; zero_mode = 1;
    rsvd = 4'hE;
    run_case("R7 R9 reserved field");
    rsvd = 4'h7;
    run_case("R7 reserved field other");
    rsvd = 4'hF; vlen = 2'd3;
    run_case("R8 length code 3");
    vlen = 2'd1; sae = 1;
    run_case("R8 sae short length");
    chk("R9 dst passthrough", dst, old_dst);
  endtask

  task automatic t_sae();
    defaults();
    src = {DEN1, SNAN, ONE, EIGHT, DEN1, SNAN, QUART, ONE};
    sae = 1;
    run_case("R11 sae 512");
    sae = 0;
    run_case("R11 sae off flags");
  endtask

  task automatic t_latency();
    logic [511:0] ed;
    logic [1:0]   ef;
    logic         eu;
    defaults();
    src = {8{EIGHT}};
    run_case("R13 first");
    src = {8{QUART}};
    #2;
    chk("R13 holds before edge", dst, {8{64'h4008_0000_0000_0000}});
    model(ed, ef, eu);
    @(negedge clk);
    chk("R13 after one edge", dst, ed);
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_lane_values();
    t_lengths();
    t_masking();
    t_bcast();
    t_flags();
    t_ud();
    t_sae();
    t_latency();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R13 watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule